// File: doc/BRIEF.md
# Multi-Mode 16-bit Down-Counting Timer

A 16-bit down counter with five operating modes, intended to keep running while most of a chip sleeps. Each step of the counter is triggered by a count source, chosen at a pin. The source can be the block clock itself, a slow always-on clock, a sub-clock, or the underflow pulse of a neighbouring timer. The slow and sub-clock inputs are level signals. They are brought into the block clock through a two-flop synchroniser, and their rising edges are then detected.

The modes are plain timing, pulse output (a pin toggles on each underflow), external event counting, active-width measurement and period measurement of an external input. Two compare channels watch the counter. Each has a toggling output pin and a one-cycle event. A single write/read port holds the reload value, the compare values, the mode and the input polarity. The same port reads back the live count and the captured measurement.

Top module: `lp_dntimer`

## Requirements
- R1: After reset the counter and the reload value read 0xFFFF. The compare values, the capture, the mode and the polarity read 0. Every output pin and event is 0.
- R2: Writes use addresses 0 = reload (also loads the counter at once, with priority over counting), 1 = compare A, 2 = compare B, 3 = control (bits 2:0 mode, bit 3 polarity). Reads use 0 = counter, 1 = compare A, 2 = compare B, 3 = control, 4 = capture, 5 = reload, and return 0 elsewhere. Mode codes 5 to 7 never step the counter.
- R3: `src_sel` 0 gives a count source tick on every clock. Codes 1 and 2 tick once per rising edge of `slow_src` or `sub_src`, seen through a two-flop synchroniser. Code 3 ticks on each cycle where `chain_uf` is high.
- R4: Mode 0 (timer) decrements once per tick. A step taken at count 0 reloads the counter from the reload value and pulses `uf_evt` for one clock.
- R5: Mode 1 (pulse output) counts as in R4, and `pulse_out` toggles on every underflow. `pulse_out` holds in all other modes.
- R6: Mode 2 (event count) decrements on each active edge of `ext_in` and ignores the count source. The active edge is rising when polarity is 0 and falling when it is 1. `ext_in` passes through the same two-flop synchroniser.
- R7: Mode 3 (width) decrements on ticks only while `ext_in` is at its active level (high for polarity 0). When the active level ends, the capture takes reload minus counter, the counter reloads and `meas_evt` pulses for one clock.
- R8: Mode 4 (period) decrements on every tick. On each active edge of `ext_in` the capture takes reload minus counter, the counter reloads and `meas_evt` pulses. A measuring edge suppresses the tick of that cycle, so `uf_evt` and `meas_evt` are never high together.
- R9: When a non-underflow decrement lands on the value of compare A (or B), `cmpa_evt` (`cmpb_evt`) pulses for one clock and `cmpa_out` (`cmpb_out`) toggles.
- R10: With `run` low the counter, the capture and all outputs hold, and no event is raised. A reload write still loads the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the fastest count source |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Count source select |
| slow_src | input | 1 | Slow always-on clock, sampled |
| sub_src | input | 1 | Sub-clock, sampled |
| chain_uf | input | 1 | Underflow pulse of another timer |
| ext_in | input | 1 | External event / pulse input |
| run | input | 1 | Counting enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, combinational |
| pulse_out | output | 1 | Toggles on underflow in pulse output mode |
| cmpa_out | output | 1 | Compare A output pin |
| cmpb_out | output | 1 | Compare B output pin |
| cmpa_evt | output | 1 | Compare A event |
| cmpb_evt | output | 1 | Compare B event |
| uf_evt | output | 1 | Underflow event |
| meas_evt | output | 1 | Measurement-complete event |

## Verification
The corner that is hardest to reach from the ports is a measuring edge of `ext_in` that arrives in the same cycle as a count tick. The input is delayed three clocks before it reaches the measuring logic, so it is hard to hit that cycle on purpose. The stimulus therefore runs the period mode with the block clock as the source, so a tick is present on every cycle, and every measuring edge collides with one. The bench model follows each synchroniser stage on every clock and compares all outputs cycle by cycle. This covers the exact latency of the slow-source edges and of the external input edges.

// File: rtl/lp_dntimer.sv
module lp_dntimer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   src_sel,
  input  logic         slow_src,
  input  logic         sub_src,
  input  logic         chain_uf,
  input  logic         ext_in,
  input  logic         run,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic         pulse_out,
  output logic         cmpa_out,
  output logic         cmpb_out,
  output logic         cmpa_evt,
  output logic         cmpb_evt,
  output logic         uf_evt,
  output logic         meas_evt
);
  localparam logic [2:0] M_TIMER = 3'd0, M_PULSE = 3'd1, M_EVENT = 3'd2,
                         M_WIDTH = 3'd3, M_PERIOD = 3'd4;

  logic [W-1:0] cnt_q, rld_q, cmpa_q, cmpb_q, cap_q;
  logic [2:0]   mode_q;
  logic         pol_q;
  logic [2:0]   sy1, sy2, sy3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; sy3 <= '0;
    end else begin
      sy1 <= {ext_in, sub_src, slow_src};
      sy2 <= sy1;
      sy3 <= sy2;
    end

  logic lvl, lvl_p, act_edge, act_end, tick, ld, meas, step, uf;
  logic [W-1:0] dec;

  assign lvl      = sy2[2] ^ pol_q;
  assign lvl_p    = sy3[2] ^ pol_q;
  assign act_edge = lvl & ~lvl_p;
  assign act_end  = ~lvl & lvl_p;
  assign ld       = wr_en && wr_addr == 3'd0;
  assign dec      = cnt_q - 1'b1;

  always_comb
    case (src_sel)
      2'd0:    tick = 1'b1;
      2'd1:    tick = sy2[0] & ~sy3[0];
      2'd2:    tick = sy2[1] & ~sy3[1];
      default: tick = chain_uf;
    endcase

  assign meas = run && !ld && ((mode_q == M_WIDTH && act_end) ||
                               (mode_q == M_PERIOD && act_edge));

  always_comb begin
    step = 1'b0;
    if (run && !ld && !meas)
      case (mode_q)
        M_TIMER, M_PULSE, M_PERIOD: step = tick;
        M_EVENT:                    step = act_edge;
        M_WIDTH:                    step = tick && lvl;
        default:                    step = 1'b0;
      endcase
  end

  assign uf = step && cnt_q == '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '1; rld_q <= '1; cmpa_q <= '0; cmpb_q <= '0; cap_q <= '0;
      mode_q <= M_TIMER; pol_q <= 1'b0;
      pulse_out <= 1'b0; cmpa_out <= 1'b0; cmpb_out <= 1'b0;
      cmpa_evt <= 1'b0; cmpb_evt <= 1'b0; uf_evt <= 1'b0; meas_evt <= 1'b0;
    end else begin
      if (wr_en)
        case (wr_addr)
          3'd0: rld_q <= wr_data;
          3'd1: cmpa_q <= wr_data;
          3'd2: cmpb_q <= wr_data;
          3'd3: {pol_q, mode_q} <= wr_data[3:0];
          default: ;
        endcase
      if (ld)        cnt_q <= wr_data;
      else if (meas) cnt_q <= rld_q;
      else if (step) cnt_q <= uf ? rld_q : dec;
      if (meas) cap_q <= rld_q - cnt_q;
      uf_evt   <= uf;
      meas_evt <= meas;
      cmpa_evt <= step && !uf && dec == cmpa_q;
      cmpb_evt <= step && !uf && dec == cmpb_q;
      if (step && !uf && dec == cmpa_q) cmpa_out <= ~cmpa_out;
      if (step && !uf && dec == cmpb_q) cmpb_out <= ~cmpb_out;
      if (uf && mode_q == M_PULSE) pulse_out <= ~pulse_out;
    end

  always_comb
    case (rd_addr)
      3'd0:    rd_data = cnt_q;
      3'd1:    rd_data = cmpa_q;
      3'd2:    rd_data = cmpb_q;
      3'd3:    rd_data = {{(W-4){1'b0}}, pol_q, mode_q};
      3'd4:    rd_data = cap_q;
      3'd5:    rd_data = rld_q;
      default: rd_data = '0;
    endcase

  // R4
  uf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |-> cnt_q == rld_q);
  // R5
  pulse_only_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_out != $past(pulse_out)) |-> uf_evt);
  // R8
  uf_meas_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({uf_evt, meas_evt}));
  // R9
  cmpa_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpa_evt && !$past(wr_en && wr_addr == 3'd1)) |-> cnt_q == cmpa_q);
  // R10
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld) |=> cnt_q == $past(cnt_q));
  // R10
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !uf_evt && !meas_evt && !cmpa_evt && !cmpb_evt);
endmodule

// File: tb/sim_lp_dntimer.sv
module sim_lp_dntimer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic slow_src = 0, sub_src = 0, chain_uf = 0, ext_in = 0, run = 0;
  logic wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic pulse_out, cmpa_out, cmpb_out, cmpa_evt, cmpb_evt, uf_evt, meas_evt;

  always #4 clk = ~clk;

  lp_dntimer u0 (.*);

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference
  int m_cnt, m_rld, m_ca, m_cb, m_cap, m_mode, m_pol;
  bit m_po, m_ao, m_bo, m_ae, m_be, m_uf, m_me;
  bit s1[3], s2[3], s3[3];

  function automatic int m_read(input int a);
    case (a)
      0: return m_cnt;
      1: return m_ca;
      2: return m_cb;
      3: return m_pol * 8 + m_mode;
      4: return m_cap;
      5: return m_rld;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 16'hFFFF; m_rld = 16'hFFFF; m_ca = 0; m_cb = 0; m_cap = 0;
      m_mode = 0; m_pol = 0;
      {m_po, m_ao, m_bo, m_ae, m_be, m_uf, m_me} = '0;
      for (int i = 0; i < 3; i++) begin s1[i] = 0; s2[i] = 0; s3[i] = 0; end
    end else begin
      bit lv, lvp, edge_a, end_a, tk, load, ms, st, u, ha, hb;
      int nxt;
      lv = s2[2] ^ m_pol[0]; lvp = s3[2] ^ m_pol[0];
      edge_a = lv && !lvp; end_a = !lv && lvp;
      tk = (src_sel == 0) ? 1'b1 : (src_sel == 1) ? (s2[0] && !s3[0]) :
           (src_sel == 2) ? (s2[1] && !s3[1]) : chain_uf;
      load = wr_en && wr_addr == 0;
      ms = run && !load && ((m_mode == 3 && end_a) || (m_mode == 4 && edge_a));
      st = 0;
      if (run && !load && !ms) begin
        if (m_mode == 0 || m_mode == 1 || m_mode == 4) st = tk;
        else if (m_mode == 2) st = edge_a;
        else if (m_mode == 3) st = tk && lv;
      end
      u = st && m_cnt == 0;
      nxt = (m_cnt - 1) & 16'hFFFF;
      ha = st && !u && nxt == m_ca;
      hb = st && !u && nxt == m_cb;
      if (ms) m_cap = (m_rld - m_cnt) & 16'hFFFF;
      if (u && m_mode == 1) m_po = !m_po;
      if (ha) m_ao = !m_ao;
      if (hb) m_bo = !m_bo;
      m_ae = ha; m_be = hb; m_uf = u; m_me = ms;
      if (load) m_cnt = wr_data;
      else if (ms) m_cnt = m_rld;
      else if (st) m_cnt = u ? m_rld : nxt;
      if (wr_en) begin
        if (wr_addr == 0) m_rld = wr_data;
        if (wr_addr == 1) m_ca = wr_data;
        if (wr_addr == 2) m_cb = wr_data;
        if (wr_addr == 3) begin m_mode = wr_data[2:0]; m_pol = wr_data[3]; end
      end
      for (int i = 0; i < 3; i++) begin s3[i] = s2[i]; s2[i] = s1[i]; end
      s1[0] = slow_src; s1[1] = sub_src; s1[2] = ext_in;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(pulse_out == m_po, "R5 pulse_out", pulse_out, m_po);
    chk(uf_evt == m_uf, "R4 uf_evt", uf_evt, m_uf);
    chk(meas_evt == m_me, "R7/R8 meas_evt", meas_evt, m_me);
    chk(cmpa_evt == m_ae && cmpa_out == m_ao, "R9 compare A", {cmpa_evt, cmpa_out}, {m_ae, m_ao});
    chk(cmpb_evt == m_be && cmpb_out == m_bo, "R9 compare B", {cmpb_evt, cmpb_out}, {m_be, m_bo});
    chk(rd_data == m_read(rd_addr), "R2 rd_data", rd_data, m_read(rd_addr));
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = a; #1 v = rd_data;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int v, a, b;
    cyc(3);
    // R1 reset state
    rd(0, v); chk(v == 16'hFFFF, "R1 counter", v, 16'hFFFF);
    rd(5, v); chk(v == 16'hFFFF, "R1 reload", v, 16'hFFFF);
    chk({pulse_out, cmpa_out, cmpb_out, uf_evt, meas_evt} == 0, "R1 outputs",
        {pulse_out, cmpa_out, cmpb_out, uf_evt, meas_evt}, 0);
    rst_n = 1; cyc(2);
    rd(4, v); chk(v == 0, "R1 capture", v, 0);

    // R2 register access, R4 timer mode
    wr(1, 3); wr(2, 1); wr(3, 0); wr(0, 3);
    rd(1, a); chk(a == 3, "R2 compare A readback", a, 3);
    rd(6, a); chk(a == 0, "R2 unmapped read", a, 0);
    rd_addr = 0; run = 1;
    b = 0;
    for (int i = 0; i < 40; i++) begin cyc(1); b += uf_evt; end
    chk(b == 10, "R4 underflow every reload+1 ticks", b, 10);

    // R5 pulse output
    wr(3, 1); a = pulse_out;
    cyc(8);
    chk(pulse_out == a, "R5 two underflows restore pin", pulse_out, a);
    cyc(20);

    // R3 slow source
    wr(3, 0); src_sel = 1; wr(0, 1000); rd(0, a);
    for (int i = 0; i < 64; i++) begin slow_src = (i % 8) < 4; cyc(1); end
    rd(0, b); chk(a - b == 8, "R3 slow source ticks", a - b, 8);
    // R3 sub source
    src_sel = 2; rd(0, a);
    for (int i = 0; i < 60; i++) begin sub_src = (i % 6) < 3; slow_src = i[0]; cyc(1); end
    rd(0, b); chk(a - b == 10, "R3 sub source ticks", a - b, 10);
    // R3 cascade
    src_sel = 3; cyc(4); rd(0, a);
    for (int i = 0; i < 3; i++) begin chain_uf = 1; cyc(1); chain_uf = 0; cyc(2); end
    rd(0, b); chk(a - b == 3, "R3 cascade ticks", a - b, 3);

    // R6 event count, falling active
    ext_in = 1; wr(3, 4'b1010); src_sel = 0; cyc(5); rd(0, a);
    for (int i = 0; i < 5; i++) begin ext_in = 0; cyc(3); ext_in = 1; cyc(3); end
    cyc(4); rd(0, b); chk(a - b == 5, "R6 falling edges counted", a - b, 5);
    wr(3, 2); ext_in = 0; cyc(5); rd(0, a);
    for (int i = 0; i < 4; i++) begin ext_in = 1; cyc(2); ext_in = 0; cyc(2); end
    cyc(4); rd(0, b); chk(a - b == 4, "R6 rising edges counted", a - b, 4);

    // R7 width
    wr(3, 3); wr(0, 100); cyc(4);
    ext_in = 1; cyc(7); ext_in = 0; cyc(6);
    rd(4, v); chk(v == 7, "R7 width capture", v, 7);

    // R8 period with tick every cycle
    wr(3, 4); wr(0, 500); rd_addr = 0; cyc(4);
    for (int p = 0; p < 3; p++) begin ext_in = 1; cyc(3); ext_in = 0; cyc(7); end
    rd(4, v); chk(v == 9, "R8 period capture", v, 9);

    // R9 compare hit on B
    wr(3, 0); wr(2, 20); wr(0, 25); rd_addr = 0;
    a = cmpb_out; cyc(8);
    chk(cmpb_out != a, "R9 compare B toggled", cmpb_out, !a);

    // R10 stopped
    run = 0; cyc(2); rd(0, a); cyc(10); rd(0, b);
    chk(a == b, "R10 counter held", b, a);
    wr(0, 42); rd(0, v); chk(v == 42, "R10 reload write while stopped", v, 42);
    // R2 reserved mode does not count
    run = 1; wr(3, 6); rd(0, a); cyc(10); rd(0, b);
    chk(a == b, "R2 reserved mode idle", b, a);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule